// File: doc/BRIEF.md
# Converter Calibration Register Bank and Sequencer

This block holds the small set of 16-bit control registers that steer a data converter's full-scale range and its self-calibration, and it runs the calibration itself. Software reaches the registers through a plain address/data port. The port has a 4-bit address, 16-bit write data, a write strobe, a read strobe and combinational read data. Three registers are mapped: a full-scale-range magnitude register, a calibration-adjust register and a calibration-result register.

A one-cycle calibration start pulse launches a sequence of steps. Each step raises a request line toward an analog engine, which is stubbed outside this block. The step then waits for that engine's done pulse. The sequence-select bit in the adjust register picks one of two sequences. The full sequence resets the calibrated elements to nominal, then calibrates the input termination, then calibrates linearity. The short sequence runs linearity calibration only. The short sequence is valid only after a full termination calibration has completed, so an early short request is promoted to a full run. When the linearity step finishes, the engine's result word is captured into the result register. Software can see or change that register only while the scan-enable bit is set.

Top module: `cal_ctrl_top`

## Requirements
- R1: After reset the full-scale register (address 3) reads 16'h4000. Its bit 15 always reads 0. Bits 14:0 are driven on `fsr_mag`.
- R2: A write to address 3 whose bits 14:0 are below 16384 stores 16384. Any other write stores bits 14:0 unchanged.
- R3: After reset the adjust register (address 4) reads 16'hDB4B. A write changes only bit 14 (sequence select) and bit 7 (scan enable). All other bits keep their reset values.
- R4: A full run raises `nom_go`, then `term_go`, then `lin_go`. Each request holds until its own done input is seen high, and the next request appears on the following cycle. At most one request is high at any time.
- R5: With sequence select at 0 and `term_valid` at 1, a start raises only `lin_go`.
- R6: With sequence select at 0 and `term_valid` at 0, a start runs the full sequence.
- R7: `term_valid` is 0 after reset. It sets when a termination step completes and stays set until reset.
- R8: While scan enable is 0, reads of address 5 return 0 and writes to address 5 are ignored. While it is 1, address 5 reads and writes the stored word.
- R9: When the linearity step completes, `cal_result` is captured into the address 5 register.
- R10: `busy` is 1 from the cycle after an accepted start until the linearity step completes. Start pulses while busy, and done pulses that do not match the current step, have no effect.
- R11: Reads of any address other than 3, 4 and 5 return 0, and reads with `bus_rd` low return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 16 | Read data (combinational) |
| cal_start | input | 1 | Calibration start pulse |
| busy | output | 1 | Sequence in progress |
| term_valid | output | 1 | Sticky: termination calibration has completed |
| fsr_mag | output | 15 | Full-scale magnitude code to the converter |
| nom_go | output | 1 | Request: reset calibrated elements to nominal |
| nom_done | input | 1 | Nominal reset finished |
| term_go | output | 1 | Request: termination calibration |
| term_done | input | 1 | Termination calibration finished |
| lin_go | output | 1 | Request: linearity calibration |
| lin_done | input | 1 | Linearity calibration finished |
| cal_result | input | 16 | Result word from the linearity engine |

## Verification
The hardest case to reach is the promotion of a short request. It happens only once after each reset, on the first start after sequence select has been cleared and before any termination step has ever finished. The bench therefore clears sequence select before its first calibration, so that promotion is taken and checked before the sticky flag sets. Random runs with stray start pulses and random step latencies then cover the short path and the busy guard.

// File: rtl/cal_pkg.sv
package cal_pkg;
    localparam int REG_W  = 16;
    localparam int ADDR_W = 4;
    localparam int MAG_W  = 15;

    localparam logic [ADDR_W-1:0] A_FSR  = 4'h3;
    localparam logic [ADDR_W-1:0] A_ADJ  = 4'h4;
    localparam logic [ADDR_W-1:0] A_CALV = 4'h5;

    localparam logic [REG_W-1:0] FSR_INIT  = 16'h4000;
    localparam logic [REG_W-1:0] ADJ_INIT  = 16'hDB4B;
    localparam int               SEL_BIT   = 14;
    localparam int               SCAN_BIT  = 7;
    localparam logic [REG_W-1:0] ADJ_WMASK = (REG_W'(1) << SEL_BIT) | (REG_W'(1) << SCAN_BIT);
    localparam logic [MAG_W-1:0] MAG_MIN   = 15'd16384;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_NOM  = 2'd1,
        SQ_TERM = 2'd2,
        SQ_LIN  = 2'd3
    } seq_state_t;

    typedef struct packed {
        logic nom;
        logic term;
        logic lin;
    } step_req_t;

    function automatic logic [MAG_W-1:0] mag_clamp(input logic [MAG_W-1:0] code);
        return (code < MAG_MIN) ? MAG_MIN : code;
    endfunction
endpackage

// File: rtl/cal_regbank.sv
module cal_regbank
    import cal_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = REG_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          wr,
    input  logic          rd,
    output logic [DW-1:0] rdata,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    output logic [MAG_W-1:0] mag,
    output logic          seq_sel,
    output logic          scan_en
);
    logic [DW-1:0] fsr_q, adj_q, calv_q;
    logic          wr_fsr, wr_adj, wr_calv;

    assign wr_fsr  = wr && (addr == AW'(A_FSR));
    assign wr_adj  = wr && (addr == AW'(A_ADJ));
    assign wr_calv = wr && (addr == AW'(A_CALV)) && scan_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            fsr_q <= FSR_INIT;
            adj_q <= ADJ_INIT;
        end else begin
            if (wr_fsr) fsr_q <= {1'b0, mag_clamp(wdata[MAG_W-1:0])};
            if (wr_adj) adj_q <= (adj_q & ~ADJ_WMASK) | (wdata & ADJ_WMASK);
        end
    end

    // Result word has no defined reset value.
    always_ff @(posedge clk) begin
        if (load)         calv_q <= load_val;
        else if (wr_calv) calv_q <= wdata;
    end

    assign mag     = fsr_q[MAG_W-1:0];
    assign seq_sel = adj_q[SEL_BIT];
    assign scan_en = adj_q[SCAN_BIT];

    always_comb begin
        rdata = '0;
        if (rd) begin
            unique case (addr)
                AW'(A_FSR):  rdata = fsr_q;
                AW'(A_ADJ):  rdata = adj_q;
                AW'(A_CALV): rdata = scan_en ? calv_q : '0;
                default:     rdata = '0;
            endcase
        end
    end

    // R2
    mag_floor_chk: assert property (@(posedge clk) disable iff (rst)
        mag >= MAG_MIN);
    // R3
    adj_reserved_chk: assert property (@(posedge clk) disable iff (rst)
        $stable(adj_q & ~ADJ_WMASK));
    // R8
    scan_block_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == AW'(A_CALV) && !scan_en && !load) |=> $stable(calv_q));
    // R9
    load_capture_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (calv_q == $past(load_val)));
endmodule

// File: rtl/cal_seq.sv
module cal_seq
    import cal_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      seq_sel,
    input  logic      nom_done,
    input  logic      term_done,
    input  logic      lin_done,
    output step_req_t req,
    output logic      busy,
    output logic      term_valid,
    output logic      load
);
    seq_state_t st_q, st_d;
    logic       full_run;

    assign full_run = seq_sel || !term_valid;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SQ_IDLE: if (start)     st_d = full_run ? SQ_NOM : SQ_LIN;
            SQ_NOM:  if (nom_done)  st_d = SQ_TERM;
            SQ_TERM: if (term_done) st_d = SQ_LIN;
            SQ_LIN:  if (lin_done)  st_d = SQ_IDLE;
            default:                st_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= SQ_IDLE;
            term_valid <= 1'b0;
        end else begin
            st_q <= st_d;
            if (st_q == SQ_TERM && term_done) term_valid <= 1'b1;
        end
    end

    assign req.nom  = (st_q == SQ_NOM);
    assign req.term = (st_q == SQ_TERM);
    assign req.lin  = (st_q == SQ_LIN);
    assign busy     = (st_q != SQ_IDLE);
    assign load     = (st_q == SQ_LIN) && lin_done;

    // R4
    one_req_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({req.nom, req.term, req.lin}));
    // R4
    nom_to_term_chk: assert property (@(posedge clk) disable iff (rst)
        (req.nom && nom_done) |=> req.term);
    // R4
    term_to_lin_chk: assert property (@(posedge clk) disable iff (rst)
        (req.term && term_done) |=> req.lin);
    // R6
    promote_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && !term_valid) |=> req.nom);
    // R7
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        term_valid |=> term_valid);
    // R10
    hold_lin_chk: assert property (@(posedge clk) disable iff (rst)
        (req.lin && !lin_done) |=> req.lin);
endmodule

// File: rtl/cal_ctrl_top.sv
module cal_ctrl_top
    import cal_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [3:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    input  logic        bus_wr,
    input  logic        bus_rd,
    output logic [15:0] bus_rdata,
    input  logic        cal_start,
    output logic        busy,
    output logic        term_valid,
    output logic [14:0] fsr_mag,
    output logic        nom_go,
    input  logic        nom_done,
    output logic        term_go,
    input  logic        term_done,
    output logic        lin_go,
    input  logic        lin_done,
    input  logic [15:0] cal_result
);
    logic      seq_sel, scan_en, load;
    step_req_t req;

    cal_regbank #(.AW(ADDR_W), .DW(REG_W)) u_regs (
        .clk(clk), .rst(rst), .addr(bus_addr), .wdata(bus_wdata),
        .wr(bus_wr), .rd(bus_rd), .rdata(bus_rdata),
        .load(load), .load_val(cal_result),
        .mag(fsr_mag), .seq_sel(seq_sel), .scan_en(scan_en)
    );

    cal_seq u_seq (
        .clk(clk), .rst(rst), .start(cal_start), .seq_sel(seq_sel),
        .nom_done(nom_done), .term_done(term_done), .lin_done(lin_done),
        .req(req), .busy(busy), .term_valid(term_valid), .load(load)
    );

    assign nom_go  = req.nom;
    assign term_go = req.term;
    assign lin_go  = req.lin;
endmodule

// File: tb/cal_ctrl_top_tb.sv
module cal_ctrl_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [15:0] bus_rdata;
    logic        cal_start = 1'b0;
    logic        busy, term_valid, nom_go, term_go, lin_go;
    logic        nom_done = 1'b0, term_done = 1'b0, lin_done = 1'b0;
    logic [14:0] fsr_mag;
    logic [15:0] cal_result = '0;

    int errors = 0;
    int checks = 0;

    logic [15:0] m_fsr, m_adj, m_calv;
    bit          m_calv_known, m_valid;

    always #10 clk = ~clk;

    cal_ctrl_top u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .cal_start(cal_start), .busy(busy), .term_valid(term_valid),
        .fsr_mag(fsr_mag), .nom_go(nom_go), .nom_done(nom_done),
        .term_go(term_go), .term_done(term_done), .lin_go(lin_go),
        .lin_done(lin_done), .cal_result(cal_result)
    );

    function automatic logic [15:0] exp_fsr(input logic [15:0] w);
        return (w[14:0] < 15'd16384) ? 16'h4000 : {1'b0, w[14:0]};
    endfunction

    function automatic logic [15:0] exp_adj(input logic [15:0] old, input logic [15:0] w);
        return (old & ~16'h4080) | (w & 16'h4080);
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
        if (a == 4'h3) m_fsr = exp_fsr(d);
        if (a == 4'h4) m_adj = exp_adj(m_adj, d);
        if (a == 4'h5 && m_adj[7]) begin m_calv = d; m_calv_known = 1; end
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic check_read(input string tag, input logic [3:0] a);
        logic [15:0] d, e;
        bus_read(a, d);
        case (a)
            4'h3: e = m_fsr;
            4'h4: e = m_adj;
            4'h5: e = m_adj[7] ? m_calv : 16'h0;
            default: e = 16'h0;
        endcase
        if (a != 4'h5 || !m_adj[7] || m_calv_known) check(tag, d, e);
    endtask

    task automatic do_step(input logic [2:0] want, input logic [15:0] res, input bit poke);
        int wait_n = int'($urandom % 3);
        for (int k = 0; k < wait_n; k++) begin
            check("R4 step request held", {13'd0, nom_go, term_go, lin_go}, {13'd0, want});
            if (poke) cal_start = 1'b1;
            @(posedge clk);
            @(negedge clk);
            cal_start = 1'b0;
        end
        check("R4 step request", {13'd0, nom_go, term_go, lin_go}, {13'd0, want});
        check("R10 busy during step", {15'd0, busy}, 16'd1);
        {nom_done, term_done, lin_done} = want;
        cal_result = res;
        @(posedge clk);
        @(negedge clk);
        {nom_done, term_done, lin_done} = 3'b000;
    endtask

    task automatic run_cal(input logic [15:0] res, input bit poke, input string tag);
        bit full = m_adj[14] || !m_valid;
        @(negedge clk);
        cal_start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cal_start = 1'b0;
        if (full) begin
            do_step(3'b100, res, poke);
            do_step(3'b010, res, poke);
            m_valid = 1;
        end
        do_step(3'b001, res, poke);
        m_calv = res; m_calv_known = 1;
        check({tag, " busy clears"}, {15'd0, busy}, 16'd0);
        check("R7 term_valid", {15'd0, term_valid}, {15'd0, m_valid});
        check({tag, " no request after run"}, {13'd0, nom_go, term_go, lin_go}, 16'd0);
    endtask

    initial begin
        logic [15:0] d;
        void'($urandom(32'd20251));
        m_fsr = 16'h4000; m_adj = 16'hDB4B; m_calv = '0; m_calv_known = 0; m_valid = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        check_read("R1 fsr reset", 4'h3);
        check_read("R3 adj reset", 4'h4);
        check("R1 fsr_mag reset", {1'b0, fsr_mag}, 16'h4000);
        check("R10 idle after reset", {15'd0, busy}, 16'd0);
        check("R7 term_valid reset", {15'd0, term_valid}, 16'd0);

        bus_write(4'h3, 16'h0123);
        check_read("R2 clamp low code", 4'h3);
        bus_write(4'h3, 16'hFFFF);
        check_read("R1 bit15 reads zero", 4'h3);
        check("R1 fsr_mag port", {1'b0, fsr_mag}, 16'h7FFF);
        bus_write(4'h3, 16'h4000);
        check_read("R2 floor code kept", 4'h3);

        bus_write(4'h4, 16'h0000);
        check_read("R3 only select/scan change", 4'h4);
        check("R3 cleared value", m_adj, 16'h9B4B);

        bus_write(4'h4, 16'h0080);
        bus_write(4'h5, 16'h1111);
        bus_write(4'h4, 16'h0000);
        bus_write(4'h5, 16'h2222);
        check_read("R8 read gated to zero", 4'h5);
        bus_write(4'h4, 16'h0080);
        check_read("R8 write ignored while gated", 4'h5);

        check_read("R11 unmapped read", 4'h0);
        bus_read(4'h3, d);
        @(negedge clk);
        bus_addr = 4'h3;
        #1 check("R11 no strobe reads zero", bus_rdata, 16'h0);

        run_cal(16'hA5C3, 1'b0, "R6 promoted run");
        check_read("R9 result captured", 4'h5);

        run_cal(16'h5A3C, 1'b0, "R5 short run");
        check_read("R9 short result", 4'h5);

        @(negedge clk);
        {nom_done, term_done, lin_done} = 3'b111;
        @(posedge clk);
        @(negedge clk);
        {nom_done, term_done, lin_done} = 3'b000;
        check("R10 stray done ignored", {14'd0, busy, lin_go}, 16'd0);

        bus_write(4'h4, 16'h4080);
        run_cal(16'h0F0F, 1'b1, "R10 start while busy");
        check_read("R9 full result", 4'h5);

        for (int i = 0; i < 60; i++) begin
            int op = int'($urandom % 5);
            logic [15:0] w = 16'($urandom);
            case (op)
                0: begin bus_write(4'h3, w); check_read("R2 random fsr", 4'h3); end
                1: begin bus_write(4'h4, w); check_read("R3 random adj", 4'h4); end
                2: begin bus_write(4'h5, w); check_read("R8 random scan access", 4'h5); end
                3: check_read("R11 random read", 4'($urandom));
                default: begin
                    run_cal(w, bit'($urandom % 2), "R4 random run");
                    check_read("R9 random result", 4'h5);
                end
            endcase
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule